// File: doc/BRIEF.md
# Multi-Rail Power-Good and Fault Supervisor

This block watches a set of digitized rail measurements and decides, on every clock, whether the rails are healthy. The inputs are a switching core rail with its moving target, two linear rails with their fixed nominals, the main supply, the linear-regulator input supply and the die temperature. Each fault flag has a set point and a separate release point, so a value that sits near a threshold does not make the flag chatter. Ratio thresholds use integer multiply-and-compare, with no division. For example, the core is "over" when `core_meas*100 > core_ref*114`.

The outputs are an overvoltage fault, undervoltage flags for the core and for each linear rail, a thermal shutdown, a battery-good level, a rail enable, a request to tri-state the core output stage, and a power-good level. Power-good is not latched. It rises and falls with the current flag state, so a soft short can make it toggle. Overvoltage must persist across a programmable number of clocks before it is reported. Enable drops power-good in the same cycle, with no register in that path.

All measurements are in millivolt codes. Temperature is an unsigned degree-Celsius code. The asynchronous active-low reset is released through a two-stage synchronizer, so the first functional update happens on the third rising edge after `rst_n` rises.

Top module: `pg_supervisor`

## Requirements
- R1: While in reset, and until the first functional edge, the outputs are: `ov_fault`=0, `uv_core`=1, `uv_ldo`=2'b11, `therm_sd`=0, `batt_ok`=0, `rails_en`=0, `stage_hiz`=1, `pgood`=0.
- R2: `ov_fault` sets on the edge that makes OV_FILT_CYC+1 consecutive edges at which `core_meas*100 > core_ref*114`. Any edge without that condition restarts the count.
- R3: Once set, `ov_fault` holds while `core_meas*100 > core_ref*106`. It clears on the first edge at which `core_meas*100 <= core_ref*106`.
- R4: `stage_hiz` is high whenever any of these hold: `ov_fault`, `therm_sd`, `en` low, `batt_ok` low.
- R5: `uv_core` sets on an edge where `core_meas*100 < core_ref*86`. It clears on an edge where `core_meas*100 > core_ref*94`. Otherwise it holds.
- R6: Bit i of `uv_ldo` sets when `ldo_meas[i]*100 < ldo_nom[i]*86` and clears when `ldo_meas[i]*100 > ldo_nom[i]*91`. The two bits act independently.
- R7: `batt_ok` sets on an edge with `vsup_meas >= 2800` and clears on an edge with `vsup_meas < 2600`. Otherwise it holds.
- R8: `therm_sd` sets on an edge with `temp_meas >= 140` and clears on an edge with `temp_meas <= 95`. Otherwise it holds.
- R9: The LDO input counts as good when `lvin_meas > 1600` was seen at the last edge. `pgood` = `en` AND `batt_ok` AND LDO input good AND none of `ov_fault`, `uv_core`, `uv_ldo`, `therm_sd`. It re-asserts as soon as the faults clear.
- R10: `en` low forces `pgood` low in the same cycle, with no clock edge needed.
- R11: `rails_en` = `en` AND `batt_ok` AND NOT `therm_sd`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Regulator enable request |
| core_meas | input | W | Core rail measurement (mV) |
| core_ref | input | W | Core rail target reference (mV) |
| ldo_meas | input | 2 x W | Linear rail measurements (mV) |
| ldo_nom | input | 2 x W | Linear rail nominals (mV) |
| vsup_meas | input | W | Main supply measurement (mV) |
| lvin_meas | input | W | Linear-regulator input supply (mV) |
| temp_meas | input | TW | Die temperature (deg C) |
| ov_fault | output | 1 | Core overvoltage fault |
| uv_core | output | 1 | Core undervoltage flag |
| uv_ldo | output | 2 | Linear rail undervoltage flags |
| therm_sd | output | 1 | Thermal shutdown |
| batt_ok | output | 1 | Supply above power-on level |
| rails_en | output | 1 | Enable for all regulators |
| stage_hiz | output | 1 | Tri-state request for core output stage |
| pgood | output | 1 | Power-good level |

## Verification
The hardest state to reach from the ports is an overvoltage that has passed its persistence filter. This needs the core ratio above 114 % on every edge of a long run, and a single sample back in range wipes out the progress. The bench holds each random input set for a random number of cycles and overrides the filter to a short length, so runs long enough to trip it occur naturally. Directed sequences then hit the exact edge count. They also break a run one cycle short, and walk the value down through the 106 % release point. Exact-boundary codes are also driven for every hysteresis threshold, to separate the strict comparisons from the non-strict ones.

// File: rtl/pg_pkg.sv
`timescale 1ns/1ps
package pg_pkg;
  localparam int unsigned PCT_BASE = 100;

  typedef enum logic {
    SIDE_LOW  = 1'b0,
    SIDE_HIGH = 1'b1
  } pg_side_e;
endpackage

// File: rtl/pg_ov_filter.sv
`timescale 1ns/1ps
module pg_ov_filter #(
  parameter int unsigned CYC = 150
) (
  input  logic clk,
  input  logic rst_n,
  input  logic hit,
  output logic arm
);
  localparam int unsigned CW = $clog2(CYC + 1);
  localparam logic [CW-1:0] CYC_V = CW'(CYC);

  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    if (!hit)
      cnt_d = '0;
    else if (cnt_q == CYC_V)
      cnt_d = cnt_q;
    else
      cnt_d = cnt_q + CW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      cnt_q <= '0;
    else
      cnt_q <= cnt_d;
  end

  assign arm = (cnt_q == CYC_V);

  // R2
  cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CYC_V);

  // R2
  cnt_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !hit |=> !arm);
endmodule

// File: rtl/pg_level_hyst.sv
`timescale 1ns/1ps
module pg_level_hyst #(
  parameter int unsigned W        = 12,
  parameter int unsigned SET_LVL  = 2800,
  parameter int unsigned CLR_LVL  = 2600,
  parameter bit          RST_FLAG = 1'b0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] lvl,
  output logic         flag
);
  localparam logic [W-1:0] SET_V = W'(SET_LVL);
  localparam logic [W-1:0] CLR_V = W'(CLR_LVL);

  logic flag_d;

  always_comb begin
    if (flag)
      flag_d = (lvl >= CLR_V);
    else
      flag_d = (lvl >= SET_V);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      flag <= RST_FLAG;
    else
      flag <= flag_d;
  end

  // R7
  lvl_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag) |-> ($past(lvl) >= SET_V));

  // R8
  lvl_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(flag) |-> ($past(lvl) < CLR_V));
endmodule

// File: rtl/pg_ratio_hyst.sv
`timescale 1ns/1ps
module pg_ratio_hyst
  import pg_pkg::*;
#(
  parameter int unsigned W        = 12,
  parameter pg_side_e    SIDE     = SIDE_LOW,
  parameter int unsigned SET_PCT  = 86,
  parameter int unsigned CLR_PCT  = 94,
  parameter int unsigned FILT_CYC = 0,
  parameter bit          RST_FLAG = 1'b1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] meas,
  input  logic [W-1:0] ref_v,
  output logic         flag
);
  localparam int unsigned PW = W + 8;

  logic [PW-1:0] m_s, r_set, r_clr;
  logic          beyond, rel_hit, arm, flag_d;

  always_comb begin
    m_s   = PW'(meas)  * PW'(PCT_BASE);
    r_set = PW'(ref_v) * PW'(SET_PCT);
    r_clr = PW'(ref_v) * PW'(CLR_PCT);
    if (SIDE == SIDE_HIGH) begin
      beyond  = (m_s >  r_set);
      rel_hit = (m_s <= r_clr);
    end else begin
      beyond  = (m_s <  r_set);
      rel_hit = (m_s >  r_clr);
    end
  end

  generate
    if (FILT_CYC > 0) begin : g_filt
      pg_ov_filter #(.CYC(FILT_CYC)) u_filt (
        .clk   (clk),
        .rst_n (rst_n),
        .hit   (beyond),
        .arm   (arm)
      );
    end else begin : g_nofilt
      assign arm = 1'b1;
    end
  endgenerate

  always_comb begin
    if (flag)
      flag_d = !rel_hit;
    else
      flag_d = beyond && arm;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      flag <= RST_FLAG;
    else
      flag <= flag_d;
  end

  // R2
  set_armed_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag) |-> $past(arm));
endmodule

// File: rtl/pg_supervisor.sv
`timescale 1ns/1ps
module pg_supervisor
  import pg_pkg::*;
#(
  parameter int unsigned W           = 12,
  parameter int unsigned TW          = 8,
  parameter int unsigned OV_FILT_CYC = 150,
  parameter int unsigned OV_SET_PCT  = 114,
  parameter int unsigned OV_CLR_PCT  = 106,
  parameter int unsigned UVC_SET_PCT = 86,
  parameter int unsigned UVC_CLR_PCT = 94,
  parameter int unsigned UVL_SET_PCT = 86,
  parameter int unsigned UVL_CLR_PCT = 91,
  parameter int unsigned POR_RISE_MV = 2800,
  parameter int unsigned POR_FALL_MV = 2600,
  parameter int unsigned LVIN_MIN_MV = 1600,
  parameter int unsigned TEMP_HOT_C  = 140,
  parameter int unsigned TEMP_COOL_C = 95
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 en,
  input  logic [W-1:0]         core_meas,
  input  logic [W-1:0]         core_ref,
  input  logic [1:0][W-1:0]    ldo_meas,
  input  logic [1:0][W-1:0]    ldo_nom,
  input  logic [W-1:0]         vsup_meas,
  input  logic [W-1:0]         lvin_meas,
  input  logic [TW-1:0]        temp_meas,
  output logic                 ov_fault,
  output logic                 uv_core,
  output logic [1:0]           uv_ldo,
  output logic                 therm_sd,
  output logic                 batt_ok,
  output logic                 rails_en,
  output logic                 stage_hiz,
  output logic                 pgood
);
  localparam int unsigned NUM_LDO = 2;

  logic [1:0] rs_q;
  logic       rst_i;
  logic       lvin_ok;
  logic       all_good;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      rs_q <= 2'b00;
    else
      rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_i = rs_q[1];

  pg_ratio_hyst #(
    .W(W), .SIDE(SIDE_HIGH), .SET_PCT(OV_SET_PCT), .CLR_PCT(OV_CLR_PCT),
    .FILT_CYC(OV_FILT_CYC), .RST_FLAG(1'b0)
  ) u_ov (
    .clk(clk), .rst_n(rst_i), .meas(core_meas), .ref_v(core_ref), .flag(ov_fault)
  );

  pg_ratio_hyst #(
    .W(W), .SIDE(SIDE_LOW), .SET_PCT(UVC_SET_PCT), .CLR_PCT(UVC_CLR_PCT),
    .FILT_CYC(0), .RST_FLAG(1'b1)
  ) u_uvc (
    .clk(clk), .rst_n(rst_i), .meas(core_meas), .ref_v(core_ref), .flag(uv_core)
  );

  generate
    for (genvar gi = 0; gi < NUM_LDO; gi++) begin : g_ldo
      pg_ratio_hyst #(
        .W(W), .SIDE(SIDE_LOW), .SET_PCT(UVL_SET_PCT), .CLR_PCT(UVL_CLR_PCT),
        .FILT_CYC(0), .RST_FLAG(1'b1)
      ) u_uvl (
        .clk(clk), .rst_n(rst_i), .meas(ldo_meas[gi]), .ref_v(ldo_nom[gi]),
        .flag(uv_ldo[gi])
      );
    end
  endgenerate

  pg_level_hyst #(
    .W(W), .SET_LVL(POR_RISE_MV), .CLR_LVL(POR_FALL_MV), .RST_FLAG(1'b0)
  ) u_por (
    .clk(clk), .rst_n(rst_i), .lvl(vsup_meas), .flag(batt_ok)
  );

  pg_level_hyst #(
    .W(TW), .SET_LVL(TEMP_HOT_C), .CLR_LVL(TEMP_COOL_C + 1), .RST_FLAG(1'b0)
  ) u_therm (
    .clk(clk), .rst_n(rst_i), .lvl(temp_meas), .flag(therm_sd)
  );

  pg_level_hyst #(
    .W(W), .SET_LVL(LVIN_MIN_MV + 1), .CLR_LVL(LVIN_MIN_MV + 1), .RST_FLAG(1'b0)
  ) u_lvin (
    .clk(clk), .rst_n(rst_i), .lvl(lvin_meas), .flag(lvin_ok)
  );

  always_comb begin
    all_good  = batt_ok && lvin_ok && !ov_fault && !uv_core &&
                (uv_ldo == 2'b00) && !therm_sd;
    pgood     = en && all_good;
    rails_en  = en && batt_ok && !therm_sd;
    stage_hiz = ov_fault || !rails_en;
  end

  // R4
  hiz_cover_chk: assert property (@(posedge clk) disable iff (!rst_i)
    (ov_fault || therm_sd || !batt_ok) |-> stage_hiz);

  // R9
  pgood_clean_chk: assert property (@(posedge clk) disable iff (!rst_i)
    pgood |-> (!stage_hiz && !uv_core && uv_ldo == 2'b00));

  // R11
  therm_off_chk: assert property (@(posedge clk) disable iff (!rst_i)
    therm_sd |-> !rails_en);
endmodule

// File: tb/pg_supervisor_test.sv
`timescale 1ns/1ps
module pg_supervisor_test;
  localparam int FILT = 8;

  logic             clk;
  logic             rst_n;
  logic             en;
  logic [11:0]      core_meas, core_ref, vsup_meas, lvin_meas;
  logic [1:0][11:0] ldo_meas, ldo_nom;
  logic [7:0]       temp_meas;
  logic             ov_fault, uv_core, therm_sd, batt_ok, rails_en, stage_hiz, pgood;
  logic [1:0]       uv_ldo;

  int n_chk = 0;
  int n_bad = 0;

  bit m_ov, m_uvc, m_bat, m_th, m_lv;
  bit [1:0] m_uvl;
  int m_cnt;

  pg_supervisor #(.OV_FILT_CYC(FILT)) uut (
    .clk(clk), .rst_n(rst_n), .en(en), .core_meas(core_meas), .core_ref(core_ref),
    .ldo_meas(ldo_meas), .ldo_nom(ldo_nom), .vsup_meas(vsup_meas),
    .lvin_meas(lvin_meas), .temp_meas(temp_meas), .ov_fault(ov_fault),
    .uv_core(uv_core), .uv_ldo(uv_ldo), .therm_sd(therm_sd), .batt_ok(batt_ok),
    .rails_en(rails_en), .stage_hiz(stage_hiz), .pgood(pgood)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic chk(string req, int act, int exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  function automatic bit hold_flag(bit cur, bit set_c, bit clr_c);
    return cur ? !clr_c : set_c;
  endfunction

  task automatic model_edge();
    int c = int'(core_meas);
    int r = int'(core_ref);
    bit over = (c * 100 > r * 114);
    bit nov = m_ov ? !(c * 100 <= r * 106) : (over && m_cnt == FILT);
    m_cnt = over ? ((m_cnt == FILT) ? FILT : m_cnt + 1) : 0;
    m_ov  = nov;
    m_uvc = hold_flag(m_uvc, c * 100 < r * 86, c * 100 > r * 94);
    for (int i = 0; i < 2; i++)
      m_uvl[i] = hold_flag(m_uvl[i], int'(ldo_meas[i]) * 100 < int'(ldo_nom[i]) * 86,
                           int'(ldo_meas[i]) * 100 > int'(ldo_nom[i]) * 91);
    m_bat = hold_flag(m_bat, int'(vsup_meas) >= 2800, int'(vsup_meas) < 2600);
    m_th  = hold_flag(m_th, int'(temp_meas) >= 140, int'(temp_meas) <= 95);
    m_lv  = int'(lvin_meas) > 1600;
  endtask

  task automatic compare_all();
    bit exp_rails = en && m_bat && !m_th;
    chk("R2/R3 ov_fault", ov_fault, m_ov);
    chk("R5 uv_core", uv_core, m_uvc);
    chk("R6 uv_ldo0", uv_ldo[0], m_uvl[0]);
    chk("R6 uv_ldo1", uv_ldo[1], m_uvl[1]);
    chk("R7 batt_ok", batt_ok, m_bat);
    chk("R8 therm_sd", therm_sd, m_th);
    chk("R11 rails_en", rails_en, exp_rails);
    chk("R4 stage_hiz", stage_hiz, m_ov || !exp_rails);
    chk("R9 pgood", pgood, en && m_bat && m_lv && !m_ov && !m_uvc && m_uvl == 2'b00 && !m_th);
  endtask

  task automatic step();
    @(posedge clk);
    model_edge();
    @(negedge clk);
    compare_all();
  endtask

  task automatic nominal();
    en = 1'b1; core_ref = 12'd1000; core_meas = 12'd1000;
    ldo_nom[0] = 12'd1100; ldo_meas[0] = 12'd1100;
    ldo_nom[1] = 12'd1300; ldo_meas[1] = 12'd1300;
    vsup_meas = 12'd3700; lvin_meas = 12'd1800; temp_meas = 8'd40;
  endtask

  initial begin
    #(1_000_000);
    n_bad++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    nominal();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 ov", ov_fault, 0); chk("R1 uvc", uv_core, 1); chk("R1 uvl", uv_ldo, 3);
    chk("R1 th", therm_sd, 0); chk("R1 bat", batt_ok, 0); chk("R1 rails", rails_en, 0);
    chk("R1 hiz", stage_hiz, 1); chk("R1 pg", pgood, 0);
    rst_n = 1'b1;
    repeat (2) @(posedge clk);
    m_ov = 0; m_uvc = 1; m_uvl = 2'b11; m_bat = 0; m_th = 0; m_lv = 0; m_cnt = 0;
    @(negedge clk);
    step();
    chk("R9 pgood nominal", pgood, 1);

    // R10: enable low drops pgood without a clock edge
    en = 1'b0; #1;
    chk("R10 pgood", pgood, 0);
    chk("R4 hiz en low", stage_hiz, 1);
    @(negedge clk); en = 1'b1; step();
    chk("R9 pgood returns", pgood, 1);

    // R2: exactly FILT+1 edges over 114 %
    core_meas = 12'd1141;
    repeat (FILT) step();
    chk("R2 ov before filter", ov_fault, 0);
    step();
    chk("R2 ov after filter", ov_fault, 1);
    chk("R4 hiz on ov", stage_hiz, 1);
    // R3: hold above 106 %, clear at exactly 106 %
    core_meas = 12'd1061; step();
    chk("R3 ov holds", ov_fault, 1);
    core_meas = 12'd1060; step();
    chk("R3 ov clears", ov_fault, 0);
    chk("R9 pgood not latched", pgood, 1);
    // R2 restart: broken one short
    core_meas = 12'd1141; repeat (FILT) step();
    core_meas = 12'd1000; step();
    core_meas = 12'd1141; repeat (FILT) step();
    chk("R2 restart", ov_fault, 0);
    core_meas = 12'd1000; step();

    // R5 boundaries
    core_meas = 12'd860; step(); chk("R5 at 86 no set", uv_core, 0);
    core_meas = 12'd859; step(); chk("R5 set", uv_core, 1);
    core_meas = 12'd940; step(); chk("R5 at 94 holds", uv_core, 1);
    core_meas = 12'd941; step(); chk("R5 clear", uv_core, 0);
    // R6 boundaries, independence (nominal 1000 on rail 0)
    ldo_nom[0] = 12'd1000; ldo_meas[0] = 12'd859; step();
    chk("R6 rail0 set", uv_ldo[0], 1); chk("R6 rail1 untouched", uv_ldo[1], 0);
    ldo_meas[0] = 12'd910; step(); chk("R6 at 91 holds", uv_ldo[0], 1);
    ldo_meas[0] = 12'd911; step(); chk("R6 clear", uv_ldo[0], 0);
    // R7 boundaries
    vsup_meas = 12'd2600; step(); chk("R7 at fall holds", batt_ok, 1);
    vsup_meas = 12'd2599; step(); chk("R7 clear", batt_ok, 0);
    vsup_meas = 12'd2799; step(); chk("R7 below rise", batt_ok, 0);
    vsup_meas = 12'd2800; step(); chk("R7 set", batt_ok, 1);
    // R8 boundaries
    temp_meas = 8'd140; step(); chk("R8 set", therm_sd, 1); chk("R11 off", rails_en, 0);
    temp_meas = 8'd96; step(); chk("R8 holds", therm_sd, 1);
    temp_meas = 8'd95; step(); chk("R8 clear", therm_sd, 0);
    // R9 LDO input threshold
    lvin_meas = 12'd1600; step(); chk("R9 lvin at min", pgood, 0);
    lvin_meas = 12'd1601; step(); chk("R9 lvin above", pgood, 1);

    // random segments, each held several cycles
    for (int s = 0; s < 400; s++) begin
      int rr = int'($urandom_range(1600, 850));
      core_ref  = 12'(rr);
      core_meas = 12'(rr * int'($urandom_range(120, 80)) / 100);
      for (int i = 0; i < 2; i++) begin
        int nn = int'($urandom_range(1300, 1000));
        ldo_nom[i]  = 12'(nn);
        ldo_meas[i] = 12'(nn * int'($urandom_range(100, 82)) / 100);
      end
      vsup_meas = 12'($urandom_range(2900, 2500));
      lvin_meas = 12'($urandom_range(1700, 1550));
      temp_meas = 8'($urandom_range(150, 85));
      en = ($urandom_range(9, 0) != 0);
      for (int k = 0; k < int'($urandom_range(12, 1)); k++) step();
    end

    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule